// File: doc/BRIEF.md
# SPI Slave Hold Guard

This block sits at the front of a serial-flash slave interface. It watches the chip-select, serial clock and serial data pins, plus one shared pin. That shared pin has two functions. After a power-on reset it works as an active-low interface reset. Once the command decoder pulses the enable-hold strobe, it works as an active-low hold input, and it keeps that function until the next power-on reset.

In hold function, a low level on the shared pin pauses the transaction in progress. The bit counter is frozen, serial clock edges are ignored, and the serial output driver is turned off. Hold entry and hold exit both take effect only while the serial clock is low. If the pin changes while the clock is high, the change waits for the next low phase. When chip select is released during a hold, the hold is abandoned and the partial word is dropped.

All pins are brought into the system clock domain through a two-flop synchroniser. The block then produces:
- a registered shift-enable pulse for each qualified serial-clock rising edge;
- the current bit position;
- the assembled receive word, MSB first, with a one-cycle strobe;
- the output-enable for the serial output driver;
- a reset request while the pin is in reset function and held low.

Top module: `spi_hold_guard`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, every output is 0 and the shared pin is in reset function.
- R2: A one-cycle `en_hold` pulse switches the shared pin to hold function. Chip-select activity and pin levels cannot undo this; only `rst` returns the pin to reset function. In hold function a low pin never raises `reset_req`.
- R3: In reset function, a synchronised low on the shared pin sets `reset_req`, forces `bit_pos` to 0 and suppresses `shift_en` for as long as the pin stays low.
- R4: In hold function with chip select low, a low pin sampled together with a low serial clock sets `hold_active`. The output appears three system clocks after the pins settle: two synchroniser stages plus one register.
- R5: If the pin falls while the synchronised serial clock is high, `hold_active` stays 0 until the serial clock is next sampled low.
- R6: Hold ends only when the pin is high and the serial clock is sampled low. A rise of the pin during a high clock keeps `hold_active` set until the clock goes low.
- R7: While `hold_active` is 1, `so_oe` is 0 and `shift_en` is 0, whatever the serial clock and data do.
- R8: `bit_pos` does not change during a hold. After the hold ends, shifting resumes from the same bit.
- R9: A synchronised high chip select clears `hold_active`, `so_oe` and `bit_pos`, including during a hold.
- R10: Each synchronised serial-clock rising edge with chip select low, no hold and no reset request pulses `shift_en` for one cycle and shifts `sdi` in, MSB first. After DW bits, `rx_data` takes the word, `rx_strobe` pulses for one cycle, and `bit_pos` returns to 0.
- R11: Hold lasts as long as the pin stays low, across any number of serial-clock toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cs_n | input | 1 | Chip select, active low (asynchronous) |
| sck | input | 1 | Serial clock pin (asynchronous) |
| sdi | input | 1 | Serial data in (asynchronous) |
| hold_rst_n | input | 1 | Shared reset/hold pin, active low |
| en_hold | input | 1 | One-cycle strobe that switches the shared pin to hold function |
| hold_active | output | 1 | Hold condition in force |
| shift_en | output | 1 | One-cycle pulse per qualified serial-clock rising edge |
| so_oe | output | 1 | Serial output driver enable (0 = high impedance) |
| reset_req | output | 1 | Interface reset request while the pin is in reset function |
| bit_pos | output | $clog2(DW) | Index of the next bit within the word |
| rx_data | output | DW | Last complete received word, MSB first |
| rx_strobe | output | 1 | One-cycle pulse when `rx_data` is updated |

## Verification
Hold is entered twice with opposite clock phases. In one case the pin falls while the serial clock is already low; in the other it falls while the clock is high. Comparing the two shows whether entry truly waits for the low phase rather than following the pin at once. Hold exit is driven the same way, with the pin rising during a high clock, so that a design releasing on the pin edge alone is exposed.

Serial clocks toggle throughout the hold, and the word is then completed. The received byte and the bit position before and after the hold show whether the counter was frozen or reset. Chip select is released inside a hold to check the abort path.

Finally, a low pin is applied in reset function, then in hold function, then again after a fresh power-on reset. This separates sticky mode logic from mode logic that follows chip select or clears early.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  typedef enum logic {
    PIN_IS_RESET = 1'b0,
    PIN_IS_HOLD  = 1'b1
  } pin_func_e;

  // positions inside the synchronised pin vector
  localparam int SV_SDI  = 0;
  localparam int SV_SCK  = 1;
  localparam int SV_PIN  = 2;
  localparam int SV_CS   = 3;
  localparam int SV_W    = 4;

  // idle levels loaded into the synchroniser on reset: cs high, pin high
  localparam logic [SV_W-1:0] SV_IDLE = 4'b1100;

endpackage

// File: rtl/shg_sync.sv
module shg_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/shg_pin_mode.sv
module shg_pin_mode
  import spi_hold_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_hold,
  output logic mode_hold
);

  pin_func_e func_q;

  always_ff @(posedge clk) begin
    if (rst)          func_q <= PIN_IS_RESET;
    else if (en_hold) func_q <= PIN_IS_HOLD;
  end

  assign mode_hold = (func_q == PIN_IS_HOLD);

endmodule

// File: rtl/shg_hold_fsm.sv
module shg_hold_fsm (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic sck_s,
  input  logic pin_s,
  input  logic mode_hold,
  output logic clr,
  output logic hold_q,
  output logic so_oe,
  output logic reset_req
);

  logic hold_nxt;

  assign clr = ~mode_hold & ~pin_s;

  always_comb begin
    hold_nxt = hold_q;
    if (cs_s || !mode_hold) hold_nxt = 1'b0;
    else if (!sck_s)        hold_nxt = ~pin_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= 1'b0;
      so_oe     <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      hold_q    <= hold_nxt;
      so_oe     <= ~cs_s & ~hold_nxt & ~clr;
      reset_req <= clr;
    end
  end

endmodule

// File: rtl/shg_shifter.sv
module shg_shifter #(
  parameter int DW = 8,
  localparam int CW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          sck_s,
  input  logic          sdi_s,
  input  logic          hold_q,
  input  logic          clr,
  output logic          shift_en,
  output logic [CW-1:0] bit_pos,
  output logic [DW-1:0] rx_data,
  output logic          rx_strobe
);

  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          sck_prev;
  logic          qual;
  logic [DW-1:0] sr, sr_nxt;

  assign qual   = sck_s & ~sck_prev & ~cs_s & ~hold_q & ~clr;
  assign sr_nxt = {sr[DW-2:0], sdi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev  <= 1'b0;
      shift_en  <= 1'b0;
      bit_pos   <= '0;
      sr        <= '0;
      rx_data   <= '0;
      rx_strobe <= 1'b0;
    end else begin
      sck_prev  <= sck_s;
      shift_en  <= qual;
      rx_strobe <= 1'b0;
      if (cs_s || clr) begin
        bit_pos <= '0;
      end else if (qual) begin
        sr <= sr_nxt;
        if (bit_pos == LAST) begin
          bit_pos   <= '0;
          rx_data   <= sr_nxt;
          rx_strobe <= 1'b1;
        end else begin
          bit_pos <= bit_pos + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_hold_guard.sv
module spi_hold_guard
  import spi_hold_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          sdi,
  input  logic          hold_rst_n,
  input  logic          en_hold,
  output logic          hold_active,
  output logic          shift_en,
  output logic          so_oe,
  output logic          reset_req,
  output logic [CW-1:0] bit_pos,
  output logic [DW-1:0] rx_data,
  output logic          rx_strobe
);

  logic [SV_W-1:0] raw_v, syn_v;
  logic            mode_hold, clr, hold_q;

  always_comb begin
    raw_v         = '0;
    raw_v[SV_CS]  = cs_n;
    raw_v[SV_PIN] = hold_rst_n;
    raw_v[SV_SCK] = sck;
    raw_v[SV_SDI] = sdi;
  end

  shg_sync #(.W(SV_W), .STAGES(SYNC_STAGES), .RST_VAL(SV_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(raw_v), .q(syn_v)
  );

  shg_pin_mode u_mode (
    .clk(clk), .rst(rst), .en_hold(en_hold), .mode_hold(mode_hold)
  );

  shg_hold_fsm u_hold (
    .clk(clk), .rst(rst),
    .cs_s(syn_v[SV_CS]), .sck_s(syn_v[SV_SCK]), .pin_s(syn_v[SV_PIN]),
    .mode_hold(mode_hold), .clr(clr), .hold_q(hold_q),
    .so_oe(so_oe), .reset_req(reset_req)
  );

  shg_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst),
    .cs_s(syn_v[SV_CS]), .sck_s(syn_v[SV_SCK]), .sdi_s(syn_v[SV_SDI]),
    .hold_q(hold_q), .clr(clr),
    .shift_en(shift_en), .bit_pos(bit_pos),
    .rx_data(rx_data), .rx_strobe(rx_strobe)
  );

  assign hold_active = hold_q;

endmodule

// File: rtl/spi_hold_guard_chk.sv
module spi_hold_guard_chk #(
  parameter int DW = 8,
  localparam int CW = (DW > 1) ? $clog2(DW) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          hold_active,
  input logic          shift_en,
  input logic          so_oe,
  input logic          reset_req,
  input logic [CW-1:0] bit_pos,
  input logic          rx_strobe
);

  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                    since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  // R7: no output drive while paused
  a_r7_hold_no_oe: assert property (@(posedge clk) disable iff (rst)
    hold_active |-> !so_oe);

  // R7: no shifting while paused
  a_r7_hold_no_shift: assert property (@(posedge clk) disable iff (rst)
    hold_active |-> !shift_en);

  // R8: counter frozen for a continuing hold
  a_r8_pos_frozen: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd2 && hold_active && $past(hold_active)) |-> $stable(bit_pos));

  // R3: reset request clears the position and blocks shifting
  a_r3_req_clears: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (!shift_en && bit_pos == '0));

  // R9: chip select released three samples ago forces idle
  a_r9_cs_idle: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4 && $past(cs_n, 3)) |-> (!hold_active && !so_oe && bit_pos == '0));

  // R10: word completion coincides with a shift and a wrapped position
  a_r10_strobe_wrap: assert property (@(posedge clk) disable iff (rst)
    rx_strobe |-> (shift_en && bit_pos == '0));

endmodule

bind spi_hold_guard spi_hold_guard_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .hold_active(hold_active),
  .shift_en(shift_en), .so_oe(so_oe), .reset_req(reset_req),
  .bit_pos(bit_pos), .rx_strobe(rx_strobe)
);

// File: tb/test_spi_hold_guard.sv
`timescale 1ns/1ps
module test_spi_hold_guard;

  localparam int DW = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, hold_rst_n = 1'b1, en_hold = 1'b0;
  logic hold_active, shift_en, so_oe, reset_req, rx_strobe;
  logic [CW-1:0] bit_pos;
  logic [DW-1:0] rx_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  spi_hold_guard #(.DW(DW)) i_spi_hold_guard (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .hold_rst_n(hold_rst_n), .en_hold(en_hold),
    .hold_active(hold_active), .shift_en(shift_en), .so_oe(so_oe),
    .reset_req(reset_req), .bit_pos(bit_pos), .rx_data(rx_data),
    .rx_strobe(rx_strobe)
  );

  // ---------------- behavioural reference ----------------
  bit q_cs[$], q_pin[$], q_sck[$], q_sdi[$];
  bit m_mode, m_hold, m_prev, m_shift, m_oe, m_req, m_stb;
  int m_pos;
  int m_word, m_rx;

  task automatic model_reset();
    q_cs = '{1, 1}; q_pin = '{1, 1}; q_sck = '{0, 0}; q_sdi = '{0, 0};
    m_mode = 0; m_hold = 0; m_prev = 0; m_shift = 0; m_oe = 0; m_req = 0;
    m_stb = 0; m_pos = 0; m_word = 0; m_rx = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (rst) begin
      model_reset();
    end else begin
      bit c, p, s, d, low_pin, nh, edge_ok;
      c = q_cs[0]; p = q_pin[0]; s = q_sck[0]; d = q_sdi[0];
      low_pin = !m_mode && !p;
      if (c || !m_mode) nh = 0;
      else if (!s)      nh = !p;
      else              nh = m_hold;
      edge_ok = s && !m_prev && !c && !m_hold && !low_pin;
      m_shift = edge_ok;
      m_oe    = !c && !nh && !low_pin;
      m_req   = low_pin;
      m_stb   = 0;
      if (c || low_pin) m_pos = 0;
      else if (edge_ok) begin
        m_word = ((m_word * 2) + d) % 256;
        if (m_pos == DW - 1) begin
          m_pos = 0; m_rx = m_word; m_stb = 1;
        end else m_pos++;
      end
      m_hold = nh;
      m_prev = s;
      if (en_hold) m_mode = 1;
      void'(q_cs.pop_front());  q_cs.push_back(cs_n);
      void'(q_pin.pop_front()); q_pin.push_back(hold_rst_n);
      void'(q_sck.pop_front()); q_sck.push_back(sck);
      void'(q_sdi.pop_front()); q_sdi.push_back(sdi);
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R4 hold_active", hold_active, m_hold);
      check("R7 so_oe",       so_oe,       m_oe);
      check("R10 shift_en",   shift_en,    m_shift);
      check("R3 reset_req",   reset_req,   m_req);
      check("R8 bit_pos",     bit_pos,     m_pos);
      check("R10 rx_strobe",  rx_strobe,   m_stb);
      check("R10 rx_data",    rx_data,     m_rx);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    sdi = b; sck = 1'b0; wait_clk(4);
    sck = 1'b1; wait_clk(4);
  endtask

  task automatic send_bits(logic [7:0] v, int first, int last);
    for (int i = first; i >= last; i--) send_bit(v[i]);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  initial begin
    wait_clk(3);
    // R1: outputs during reset
    check("R1 hold during rst", hold_active, 0);
    check("R1 oe during rst", so_oe, 0);
    rst = 1'b0;
    wait_clk(1);
    check("R1 req after rst", reset_req, 0);
    check("R1 pos after rst", bit_pos, 0);
    check("R1 shift after rst", shift_en, 0);

    // R10: plain byte in reset function
    cs_n = 1'b0; wait_clk(5);
    check("R7 oe with cs low", so_oe, 1);
    send_bits(8'hA5, 7, 0);
    wait_clk(4);
    check("R10 byte A5", rx_data, 8'hA5);

    // R3: pin low in reset function mid-word
    sck = 1'b0; wait_clk(4);
    send_bits(8'hFF, 7, 5);
    check("R3 pos before req", bit_pos, 3);
    hold_rst_n = 1'b0; wait_clk(4);
    check("R3 reset_req set", reset_req, 1);
    check("R3 pos cleared", bit_pos, 0);
    send_bit(1'b1);
    check("R3 no shift while req", bit_pos, 0);
    check("R4 no hold in reset function", hold_active, 0);
    hold_rst_n = 1'b1; wait_clk(4);
    cs_n = 1'b1; wait_clk(4);

    // R2: switch to hold function; cs toggles do not revert
    en_hold = 1'b1; wait_clk(1); en_hold = 1'b0;
    cs_n = 1'b0; wait_clk(4); cs_n = 1'b1; wait_clk(4);
    hold_rst_n = 1'b0; wait_clk(5);
    check("R2 no reset_req in hold function", reset_req, 0);
    hold_rst_n = 1'b1; wait_clk(4);

    // R4/R8/R11/R6: hold entered with clock low
    sck = 1'b0; cs_n = 1'b0; wait_clk(5);
    send_bits(8'h3C, 7, 5);
    sck = 1'b0; wait_clk(4);
    hold_rst_n = 1'b0; wait_clk(2);
    check("R4 not yet (sync latency)", hold_active, 0);
    wait_clk(1);
    check("R4 hold after 3 clocks", hold_active, 1);
    check("R7 oe off in hold", so_oe, 0);
    for (int k = 0; k < 6; k++) send_bit(k[0]);
    check("R11 still held after toggles", hold_active, 1);
    check("R8 pos frozen", bit_pos, 3);
    hold_rst_n = 1'b1; wait_clk(6);
    check("R6 exit waits for clock low", hold_active, 1);
    sck = 1'b0; wait_clk(4);
    check("R6 exit at clock low", hold_active, 0);
    check("R8 pos kept after hold", bit_pos, 3);
    send_bits(8'h3C, 4, 0);
    wait_clk(4);
    check("R8 byte resumed 3C", rx_data, 8'h3C);

    // R5: pin falls while clock high
    sck = 1'b0; wait_clk(4); sck = 1'b1; wait_clk(4);
    hold_rst_n = 1'b0; wait_clk(6);
    check("R5 entry deferred", hold_active, 0);
    sck = 1'b0; wait_clk(4);
    check("R5 entry at clock low", hold_active, 1);

    // R9: chip select released inside hold
    cs_n = 1'b1; wait_clk(4);
    check("R9 hold cleared", hold_active, 0);
    check("R9 pos cleared", bit_pos, 0);
    check("R9 oe off", so_oe, 0);
    hold_rst_n = 1'b1; cs_n = 1'b0; wait_clk(4);
    send_bits(8'h96, 7, 0);
    wait_clk(4);
    check("R9 fresh byte 96", rx_data, 8'h96);
    cs_n = 1'b1; wait_clk(4);

    // R2: power-on reset returns the pin to reset function
    rst = 1'b1; wait_clk(2); rst = 1'b0; wait_clk(2);
    hold_rst_n = 1'b0; wait_clk(4);
    check("R2 reset function after rst", reset_req, 1);
    hold_rst_n = 1'b1; wait_clk(6);

    finish_run();
  end

endmodule